// File: doc/BRIEF.md
# Bus-Cycle Snoop Capture Front End

This block watches the data bus of an 8-bit processor and turns each bus cycle into one captured byte. A capture happens when the bus phase signal goes from high to low. The byte goes into a first-in first-out buffer, 4096 entries deep, which a host streaming link drains through a valid/ready byte stream. The sustained capture rate is one byte per bus cycle. At a 2 MHz bus that is 2 MB/s, far below one byte per core clock, so the buffer only has to absorb stalls on the host side.

The block has two capture modes, latched while capture is disabled:

- **Every-cycle mode** records every bus cycle and ignores the select input.
- **Selected-only mode** records only cycles where the active-low device select is asserted.

A select-qualified window opens when the select is active and the phase is low. In selected-only mode the select often asserts while the phase is already low. That opening creates a spurious leading capture, which carries a stale address byte. The block recognises such an opening and drops it, so only the byte taken on the following phase fall is kept.

When the buffer is full, new samples are discarded and the older contents are kept. A sticky overflow flag is set, and a dropped-sample counter increments. The host can therefore see that data was lost, rather than finding silent gaps in the stream.

Top module: `bus_snoop_capture`

## Requirements
- R1: In every-cycle mode (mode_sel latched 0), each high-to-low transition of bus_phase while cap_en is 1 enqueues exactly one byte, the value of bus_data in the clock cycle where bus_phase is first seen low; bus_sel_n has no effect.
- R2: In selected-only mode (mode_sel latched 1), a byte is enqueued on a high-to-low transition of bus_phase only if bus_sel_n is 0 in that cycle; phase falls with bus_sel_n at 1 enqueue nothing.
- R3: In selected-only mode, when bus_sel_n goes from 1 to 0 while bus_phase is already low, the opening capture is discarded and never reaches the output; the next phase fall with the select still active enqueues the real byte.
- R4: mode_sel is taken only in cycles where cap_en is 0; a change of mode_sel while cap_en is 1 has no effect until capture has been disabled and re-enabled.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R6: Bytes leave in the order they were captured; out_valid is 1 exactly when the buffer holds at least one byte; one byte is removed per cycle with out_valid and out_ready both 1; capacity is 4096 bytes.
- R7: A capture arriving while the buffer holds 4096 bytes is dropped, even if a byte is read in the same cycle, and ovf_flag becomes 1 and stays 1 until reset.
- R8: drop_count increases by exactly one for every dropped capture.
- R9: A synchronous active-high rst empties the buffer, clears ovf_flag and drop_count, and resets the edge state so that the first capture after reset needs a fresh bus_phase fall (or, in selected-only mode, a fresh select-qualified opening).
- R10: While cap_en is 0, no byte is enqueued whatever bus_phase, bus_sel_n and bus_data do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; bus inputs are assumed synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable |
| mode_sel | input | 1 | 0 every-cycle, 1 selected-only; latched while cap_en is 0 |
| bus_phase | input | 1 | Bus phase clock, capture on its fall |
| bus_sel_n | input | 1 | Active-low device select |
| bus_data | input | 8 | Processor data bus |
| out_data | output | 8 | Oldest captured byte |
| out_valid | output | 1 | Buffer not empty |
| out_ready | input | 1 | Host accepts out_data this cycle |
| ovf_flag | output | 1 | Sticky: a capture was dropped |
| drop_count | output | 16 | Number of dropped captures |

## Verification
The hardest states to reach from the ports are the full buffer and the select opening inside a low phase. To reach the full buffer, the bench holds out_ready low through more than 4096 bus cycles, then releases it. To reach the select opening, the bench applies timed phase/select sequences that lower bus_sel_n between phase edges, with a decoy byte on the bus, and then checks that only the byte of the next phase fall arrives. A behavioural queue model runs beside the design. It is compared every clock, so draining the full buffer, stalls and order are checked as they happen.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        CAP_EVERY    = 1'b0,
        CAP_SELECTED = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic              fire;   // a capture window opened this cycle
        logic              spur;   // the opening came from the select, not the phase
        logic [BYTE_W-1:0] value;
    } snoop_evt_t;

    function automatic logic [15:0] sat_inc16(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

endpackage

// File: rtl/snoop_edge.sv
module snoop_edge
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  cap_mode_e         mode,
    input  logic              bus_phase,
    input  logic              bus_sel_n,
    input  logic [BYTE_W-1:0] bus_data,
    output snoop_evt_t        evt,
    output logic              keep
);
    logic phase_q;
    logic window_q;
    logic sel_ok;
    logic window;
    logic phase_fell;

    always_comb begin
        sel_ok     = (mode == CAP_SELECTED) ? ~bus_sel_n : 1'b1;
        window     = sel_ok & ~bus_phase;
        phase_fell = phase_q & ~bus_phase;
        evt.fire   = cap_en & window & ~window_q;
        evt.spur   = evt.fire & ~phase_fell;
        evt.value  = bus_data;
        keep       = evt.fire & ~evt.spur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= 1'b0;
            window_q <= 1'b1;
        end else begin
            phase_q  <= bus_phase;
            window_q <= window;
        end
    end
endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo
    import snoop_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    output logic              drop,
    output logic [BYTE_W-1:0] head_data,
    output logic              head_valid,
    input  logic              head_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [AW:0]       count;
    logic              full;
    logic              wr_ok;
    logic              rd_ok;

    always_comb begin
        full       = (count == FULL_CNT);
        head_valid = (count != '0);
        wr_ok      = push & ~full;
        drop       = push & full;
        rd_ok      = head_valid & head_ready;
        head_data  = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/snoop_drop_ctr.sv
module snoop_drop_ctr
    import snoop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        drop,
    output logic        ovf,
    output logic [15:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            cnt <= '0;
        end else if (drop) begin
            ovf <= 1'b1;
            cnt <= sat_inc16(cnt);
        end
    end
endmodule

// File: rtl/bus_snoop_capture.sv
module bus_snoop_capture
    import snoop_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_en,
    input  logic        mode_sel,
    input  logic        bus_phase,
    input  logic        bus_sel_n,
    input  logic [7:0]  bus_data,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        ovf_flag,
    output logic [15:0] drop_count
);
    cap_mode_e  mode_q;
    snoop_evt_t evt;
    logic       keep;
    logic       drop;

    // mode only follows the pin while capture is off
    always_ff @(posedge clk) begin
        if (rst)         mode_q <= CAP_EVERY;
        else if (!cap_en) mode_q <= cap_mode_e'(mode_sel);
    end

    snoop_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .mode      (mode_q),
        .bus_phase (bus_phase),
        .bus_sel_n (bus_sel_n),
        .bus_data  (bus_data),
        .evt       (evt),
        .keep      (keep)
    );

    snoop_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (keep),
        .push_data  (evt.value),
        .drop       (drop),
        .head_data  (out_data),
        .head_valid (out_valid),
        .head_ready (out_ready)
    );

    snoop_drop_ctr u_drop (
        .clk  (clk),
        .rst  (rst),
        .drop (drop),
        .ovf  (ovf_flag),
        .cnt  (drop_count)
    );
endmodule

// File: rtl/bus_snoop_capture_chk.sv
module bus_snoop_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        cap_en,
    input logic [7:0]  out_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic        ovf_flag,
    input logic [15:0] drop_count
);
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    // R8
    drop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> ((drop_count == $past(drop_count) + 16'd1) && ovf_flag));

    // R10
    idle_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !out_valid) |=> !out_valid);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_flag && drop_count == 16'd0));
endmodule

bind bus_snoop_capture bus_snoop_capture_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .ovf_flag   (ovf_flag),
    .drop_count (drop_count)
);

// File: tb/bus_snoop_capture_tb.sv
`timescale 1ns/1ps
module bus_snoop_capture_tb;
    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en = 1'b0;
    logic        mode_sel = 1'b0;
    logic        bus_phase = 1'b1;
    logic        bus_sel_n = 1'b1;
    logic [7:0]  bus_data = 8'h00;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        ovf_flag;
    logic [15:0] drop_count;

    always #2 clk = ~clk;

    bus_snoop_capture #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .mode_sel(mode_sel),
        .bus_phase(bus_phase), .bus_sel_n(bus_sel_n), .bus_data(bus_data),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .ovf_flag(ovf_flag), .drop_count(drop_count)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // ---------------- reference model ----------------
    logic [7:0] q[$];
    bit         m_ph_q  = 0;
    bit         m_win_q = 1;
    bit         m_mode  = 0;
    bit         m_ovf   = 0;
    int         m_drops = 0;

    always @(posedge clk) begin
        bit sel_ok, win, fire, real_byte, full;
        int sz;
        cycles++;
        if (rst) begin
            q.delete(); m_ph_q = 0; m_win_q = 1; m_mode = 0; m_ovf = 0; m_drops = 0;
        end else begin
            sel_ok    = m_mode ? !bus_sel_n : 1'b1;
            win       = sel_ok && !bus_phase;
            fire      = cap_en && win && !m_win_q;
            real_byte = fire && m_ph_q && !bus_phase;
            sz        = q.size();
            full      = (sz == DEPTH);
            if (sz > 0 && out_ready) void'(q.pop_front());
            if (real_byte) begin
                if (full) begin m_ovf = 1; if (m_drops < 65535) m_drops++; end
                else q.push_back(bus_data);
            end
            if (!cap_en) m_mode = mode_sel;
            m_ph_q  = bus_phase;
            m_win_q = win;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R6 out_valid", {31'd0, out_valid}, {31'd0, q.size() > 0});
            if (q.size() > 0) chk("R6 out_data order", {24'd0, out_data}, {24'd0, q[0]});
            chk("R7 ovf_flag", {31'd0, ovf_flag}, {31'd0, m_ovf});
            chk("R8 drop_count", {16'd0, drop_count}, m_drops);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic apply(input bit ph, input bit sn, input logic [7:0] d, input int n);
        @(posedge clk); #1;
        bus_phase = ph; bus_sel_n = sn; bus_data = d;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic every_cycle(input logic [7:0] d, input bit sn);
        apply(1, sn, 8'h00, 2);
        apply(0, sn, d, 2);
    endtask

    // select opens while phase is low: spurious byte first, real byte next fall
    task automatic sel_with_spur(input logic [7:0] spur, input logic [7:0] real_d);
        apply(1, 1, 8'h00, 2);
        apply(0, 1, 8'h11, 2);
        apply(0, 0, spur, 2);
        apply(1, 0, real_d, 2);
        apply(0, 0, real_d, 2);
        apply(1, 1, 8'h00, 2);
    endtask

    task automatic sel_clean(input logic [7:0] real_d);
        apply(1, 0, 8'h00, 2);
        apply(0, 0, real_d, 2);
        apply(1, 1, 8'h00, 2);
    endtask

    task automatic set_ctl(input bit en, input bit md, input bit rdy);
        @(posedge clk); #1;
        cap_en = en; mode_sel = md; out_ready = rdy;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cycles >= 200000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        settle();
        chk("R9 reset out_valid", {31'd0, out_valid}, 0);
        chk("R9 reset ovf_flag", {31'd0, ovf_flag}, 0);
        chk("R9 reset drop_count", {16'd0, drop_count}, 0);

        // R10: disabled, phase activity ignored
        for (int i = 0; i < 3; i++) every_cycle(8'h70 + 8'(i), 0);
        settle();
        chk("R10 no capture while disabled", {31'd0, out_valid}, 0);

        // R1: every-cycle mode, select ignored
        set_ctl(1, 0, 0);
        for (int i = 0; i < 5; i++) every_cycle(8'h10 + 8'(i), 1'(i));
        settle();
        chk("R1 first byte", {24'd0, out_data}, 32'h10);
        chk("R1 count", q.size(), 5);

        // R5: stall holds data
        held = out_data;
        repeat (5) @(posedge clk);
        settle();
        chk("R5 stall valid", {31'd0, out_valid}, 1);
        chk("R5 stall data", {24'd0, out_data}, {24'd0, held});

        // R6: drain in order (per-cycle compare checks order)
        set_ctl(1, 0, 1);
        repeat (8) @(posedge clk);
        settle();
        chk("R6 drained", {31'd0, out_valid}, 0);

        // R2 / R3: selected-only mode
        set_ctl(0, 1, 0);
        set_ctl(1, 1, 0);
        sel_with_spur(8'hFE, 8'hA5);
        settle();
        chk("R3 real byte kept", {24'd0, out_data}, 32'hA5);
        chk("R3 spurious byte dropped", q.size(), 1);
        sel_clean(8'h5C);
        for (int i = 0; i < 3; i++) every_cycle(8'h90 + 8'(i), 1);
        settle();
        chk("R2 only selected cycles", q.size(), 2);
        set_ctl(1, 1, 1);
        @(posedge clk); settle();
        chk("R2 selected byte", {24'd0, out_data}, 32'h5C);
        repeat (3) @(posedge clk);

        // R4: mode change during capture ignored
        set_ctl(1, 0, 0);
        for (int i = 0; i < 3; i++) every_cycle(8'h40 + 8'(i), 1);
        settle();
        chk("R4 mode change ignored while enabled", {31'd0, out_valid}, 0);
        set_ctl(0, 0, 0);
        set_ctl(1, 0, 0);
        every_cycle(8'h77, 1);
        settle();
        chk("R4 mode taken after re-enable", {24'd0, out_data}, 32'h77);
        set_ctl(1, 0, 1);
        repeat (3) @(posedge clk);
        set_ctl(1, 0, 0);

        // R7 / R8: overflow
        for (int i = 0; i < DEPTH + 3; i++) every_cycle(8'(i), 1);
        settle();
        chk("R7 overflow flag", {31'd0, ovf_flag}, 1);
        chk("R8 dropped count", {16'd0, drop_count}, 3);
        chk("R7 oldest kept", {24'd0, out_data}, 32'h00);
        set_ctl(1, 0, 1);
        repeat (DEPTH + 4) @(posedge clk);
        settle();
        chk("R7 flag sticky after drain", {31'd0, ovf_flag}, 1);
        chk("R6 fully drained", {31'd0, out_valid}, 0);

        // R9: reset mid-operation
        set_ctl(1, 0, 0);
        every_cycle(8'h3C, 1);
        @(posedge clk); #1 rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        settle();
        chk("R9 reset empties", {31'd0, out_valid}, 0);
        chk("R9 reset clears ovf", {31'd0, ovf_flag}, 0);
        chk("R9 reset clears drops", {16'd0, drop_count}, 0);
        every_cycle(8'h6B, 1);
        settle();
        chk("R9 capture after reset", {24'd0, out_data}, 32'h6B);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule